// File: doc/BRIEF.md
# Clock Source Selector Bank

This block is a bank of six independent clock source selectors driven from one 32-bit control word. Each selector picks one of seven source clocks (an auxiliary PLL clock and six generator outputs) or none at all, then divides the chosen clock by a small ratio taken from a four-entry table. The result is a gated, divided clock output per selector. The source clocks are oversampled by the block clock `clk`. Every output is a registered level in that domain, so source changes, divide changes and gating all happen at clean points of the output waveform.

Software writes the whole control word at once. Each selector owns a 5-bit slot. A source code of zero turns a selector off. A per-selector resume strobe turns it back on with the last non-zero source it was given. An elaboration parameter chooses between two divide tables. The second table replaces a duplicate divide-by-1 entry with divide-by-3.

Top module: `clksel_bank`

## Requirements
- R1: Writing `wr_data` with `wr_en` high stores it, and `rd_data` returns it from the next cycle. Selector i uses bits 5i+4..5i: bits 5i+1..5i hold the divide code and bits 5i+4..5i+2 hold the source code. Bits 31..30 always read 0.
- R2: While a slot's source code is 0, its output is held low once the current high phase has ended.
- R3: Source code 1 selects `src_clk[0]` (the auxiliary PLL clock). Codes 2..7 select `src_clk[1]`..`src_clk[6]` (generators 0..5).
- R4: With `ALT_TABLE`=0, divide codes 0, 1, 2 and 3 give ratios 1, 4, 1 and 2.
- R5: With `ALT_TABLE`=1, divide codes 0, 1, 2 and 3 give ratios 1, 4, 3 and 2.
- R6: Ratio 1 follows the source's levels. Ratios 2 and 4 have a 50% duty cycle. Ratio 3 is high for one source period out of three.
- R7: A one-cycle `resume[i]` pulse without `wr_en` loads slot i's source code with its last non-zero value. When the reset value of the slot's source is 0, that remembered value starts as 1.
- R8: A source change is glitch-free. The change is applied only while the output is low. The old source is gated off before the new one is gated on, and no high pulse is ever shortened.
- R9: A change of divide code alone restarts the divider. The first high pulse after the change starts on a source rising edge and has the full length for the new ratio.
- R10: A write that leaves a slot's field unchanged does not disturb that slot's output waveform.
- R11: After reset the control word equals `RST_CTRL` (0 by default) and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; oversamples the source clocks |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write value |
| resume | input | 6 | Per-selector strobe: re-enable with the remembered source |
| rd_data | output | 32 | Current control word |
| src_clk | input | 7 | Source clocks: [0] auxiliary PLL, [6:1] generators 0..5 |
| clk_out | output | 6 | Gated, divided clock per selector |

## Verification
The bench moves a selector between sources with different periods, and changes a divide code while the output is high. A design that switched at once would cut a high pulse short, and a global monitor flags any high pulse shorter than the fastest source's half period. Divide code 2 is measured on both table variants: a design that ignored the parameter would give the same pulse widths on both. A disable followed by a resume is checked through the read-back source field and the pulse widths that return, which catches a design that forgot the remembered source or restored zero. One slot is rewritten while another slot's period is being measured, to expose cross-talk between slots.

// File: rtl/clkmux_pkg.sv
package clkmux_pkg;

   // Field widths fixed by the divide table and the source count
   localparam int SRC_W    = 3;
   localparam int DIV_W    = 2;
   localparam int SLOT_W   = SRC_W + DIV_W;
   localparam int SRC_SPAN = 2 ** SRC_W;   // code 0 means "off"
   localparam int RATIO_W  = 3;

   typedef struct packed {
      logic [SRC_W-1:0] src;
      logic [DIV_W-1:0] div;
   } slot_t;

   // Standard table: the codes are deliberately not in ratio order
   function automatic logic [RATIO_W-1:0] ratio_std(input logic [DIV_W-1:0] code);
      case (code)
         2'd0:    return 3'd1;
         2'd1:    return 3'd4;
         2'd2:    return 3'd1;
         default: return 3'd2;
      endcase
   endfunction

   // Alternate table: code 2 gives the odd ratio
   function automatic logic [RATIO_W-1:0] ratio_alt(input logic [DIV_W-1:0] code);
      case (code)
         2'd0:    return 3'd1;
         2'd1:    return 3'd4;
         2'd2:    return 3'd3;
         default: return 3'd2;
      endcase
   endfunction

   // Number of counter states, counted from the restart, during which the output is high
   function automatic logic [RATIO_W-1:0] high_states(input logic [RATIO_W-1:0] ratio);
      return (ratio == 3'd3) ? 3'd1 : (ratio >> 1);
   endfunction

endpackage

// File: rtl/clksel_sync.sv
module clksel_sync #(
   parameter int N_SRC = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src_i,
   output logic [N_SRC-1:0] lvl_o,
   output logic [N_SRC-1:0] rise_o
);
   // One synchronizer and edge detector per source, shared by all selectors
   for (genvar s = 0; s < N_SRC; s++) begin : g_src
      logic meta_q, sync_q, prev_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
         end else begin
            meta_q <= src_i[s];
            sync_q <= meta_q;
            prev_q <= sync_q;
         end
      end
      assign lvl_o[s]  = sync_q;
      assign rise_o[s] = sync_q & ~prev_q;
   end
endmodule

// File: rtl/clksel_regs.sv
module clksel_regs
   import clkmux_pkg::*;
#(
   parameter int               NUM_SEL  = 6,
   parameter int               CTRL_W   = 32,
   parameter logic [CTRL_W-1:0] RST_CTRL = '0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [CTRL_W-1:0]         wr_data,
   input  logic [NUM_SEL-1:0]        resume,
   output logic [NUM_SEL*SLOT_W-1:0] ctrl_o
);
   localparam int USED_W = NUM_SEL * SLOT_W;

   for (genvar i = 0; i < NUM_SEL; i++) begin : g_slot
      localparam slot_t RST_SLOT = RST_CTRL[i*SLOT_W +: SLOT_W];
      localparam logic [SRC_W-1:0] RST_MEM =
         (RST_SLOT.src != '0) ? RST_SLOT.src : SRC_W'(1);

      slot_t            fld_q;
      logic [SRC_W-1:0] mem_q;   // last non-zero source code
      slot_t            wr_fld;

      assign wr_fld = wr_data[i*SLOT_W +: SLOT_W];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            fld_q <= RST_SLOT;
            mem_q <= RST_MEM;
         end else if (wr_en) begin
            fld_q <= wr_fld;
            if (wr_fld.src != '0) mem_q <= wr_fld.src;
         end else if (resume[i]) begin
            fld_q.src <= mem_q;
         end
      end
      assign ctrl_o[i*SLOT_W +: SLOT_W] = fld_q;
   end

   if (CTRL_W > USED_W) begin : g_spare
      logic unused_spare;
      assign unused_spare = ^wr_data[CTRL_W-1:USED_W];
   end
endmodule

// File: rtl/clksel_slot.sv
module clksel_slot
   import clkmux_pkg::*;
#(
   parameter bit ALT_TABLE = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SRC_SPAN-1:0] lvl_i,    // index = source code, bit 0 tied low
   input  logic [SRC_SPAN-1:0] rise_i,
   input  slot_t               req_i,
   output logic                clk_o,
   output logic [SRC_W-1:0]    act_src_o
);
   slot_t               act_q;
   logic [1:0]          cnt_q;
   logic [1:0]          cnt_nxt;
   logic                restart_q;
   logic                out_q;
   logic [RATIO_W-1:0]  ratio;
   logic                pending;
   logic                req_lvl;

   if (ALT_TABLE) begin : g_alt
      assign ratio = ratio_alt(act_q.div);
   end else begin : g_std
      assign ratio = ratio_std(act_q.div);
   end

   assign pending = (req_i != act_q);
   assign req_lvl = lvl_i[req_i.src];

   always_comb begin
      if (restart_q)                           cnt_nxt = 2'd0;
      else if ({1'b0, cnt_q} == ratio - 3'd1)  cnt_nxt = 2'd0;
      else                                     cnt_nxt = cnt_q + 2'd1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q     <= '0;
         cnt_q     <= 2'd0;
         restart_q <= 1'b1;
         out_q     <= 1'b0;
      end else if (pending && !out_q) begin
         // Reconfigure only in a low phase: gate off first, then gate on while the new source is low
         if (act_q.src != '0 && act_q.src != req_i.src) begin
            act_q.src <= '0;
         end else if (!req_lvl) begin
            act_q     <= req_i;
            restart_q <= 1'b1;
         end
      end else if (act_q.src != '0) begin
         if (ratio == 3'd1) begin
            out_q <= lvl_i[act_q.src];
            if (rise_i[act_q.src]) restart_q <= 1'b0;
         end else if (rise_i[act_q.src]) begin
            cnt_q     <= cnt_nxt;
            restart_q <= 1'b0;
            out_q     <= ({1'b0, cnt_nxt} < high_states(ratio));
         end
      end
   end

   assign clk_o     = out_q;
   assign act_src_o = act_q.src;
endmodule

// File: rtl/clksel_bank.sv
module clksel_bank
   import clkmux_pkg::*;
#(
   parameter int                NUM_SEL   = 6,
   parameter int                CTRL_W    = 32,
   parameter bit                ALT_TABLE = 1'b0,
   parameter logic [CTRL_W-1:0] RST_CTRL  = '0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [CTRL_W-1:0]    wr_data,
   input  logic [NUM_SEL-1:0]   resume,
   output logic [CTRL_W-1:0]    rd_data,
   input  logic [SRC_SPAN-2:0]  src_clk,
   output logic [NUM_SEL-1:0]   clk_out
);
   localparam int NUM_SRC = SRC_SPAN - 1;
   localparam int USED_W  = NUM_SEL * SLOT_W;

   initial begin
      if (USED_W > CTRL_W)
         $error("clksel_bank: %0d slots do not fit a %0d-bit control word", NUM_SEL, CTRL_W);
      if (NUM_SEL < 1)
         $error("clksel_bank: NUM_SEL must be at least 1");
   end

   logic [USED_W-1:0]        ctrl;
   logic [NUM_SRC-1:0]       lvl, rise;
   logic [SRC_SPAN-1:0]      lvl_ext, rise_ext;
   logic [NUM_SEL*SRC_W-1:0] act_src_flat;

   clksel_regs #(
      .NUM_SEL (NUM_SEL),
      .CTRL_W  (CTRL_W),
      .RST_CTRL(RST_CTRL)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_data(wr_data),
      .resume (resume),
      .ctrl_o (ctrl)
   );

   clksel_sync #(.N_SRC(NUM_SRC)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .src_i (src_clk),
      .lvl_o (lvl),
      .rise_o(rise)
   );

   assign lvl_ext  = {lvl, 1'b0};
   assign rise_ext = {rise, 1'b0};

   for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
      clksel_slot #(.ALT_TABLE(ALT_TABLE)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .lvl_i    (lvl_ext),
         .rise_i   (rise_ext),
         .req_i    (ctrl[i*SLOT_W +: SLOT_W]),
         .clk_o    (clk_out[i]),
         .act_src_o(act_src_flat[i*SRC_W +: SRC_W])
      );
   end

   if (CTRL_W > USED_W) begin : g_pad
      assign rd_data = {{(CTRL_W-USED_W){1'b0}}, ctrl};
   end else begin : g_full
      assign rd_data = ctrl;
   end
endmodule

// File: rtl/clksel_bank_chk.sv
module clksel_bank_chk #(
   parameter int NUM_SEL = 6,
   parameter int CTRL_W  = 32
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 wr_en,
   input logic [CTRL_W-1:0]    wr_data,
   input logic [NUM_SEL-1:0]   resume,
   input logic [CTRL_W-1:0]    rd_data,
   input logic [NUM_SEL-1:0]   clk_out,
   input logic [NUM_SEL*3-1:0] act_src_flat
);
   localparam int          USED_W = NUM_SEL * 5;
   localparam logic [CTRL_W-1:0] MASK = CTRL_W'((64'd1 << USED_W) - 64'd1);

   // R1: a write is visible on the read port in the next cycle
   a_r1_readback: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en) |-> rd_data == ($past(wr_data) & MASK));

   for (genvar i = 0; i < NUM_SEL; i++) begin : g_chk
      // R2: an output that is already low stays low while the source code is 0
      a_r2_off_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_data[i*5+2 +: 3] == 3'd0 && $past(rd_data[i*5+2 +: 3]) == 3'd0
          && !$past(clk_out[i])) |-> !clk_out[i]);

      // R7: a resume strobe always yields a non-zero source code
      a_r7_resume_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
         (resume[i] && !wr_en) |=> rd_data[i*5+2 +: 3] != 3'd0);

      // R8: the active source moves only after a low output cycle
      a_r8_switch_when_low: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(act_src_flat[i*3 +: 3]) |-> !$past(clk_out[i]));
   end
endmodule

bind clksel_bank clksel_bank_chk #(
   .NUM_SEL(NUM_SEL),
   .CTRL_W (CTRL_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_data     (wr_data),
   .resume      (resume),
   .rd_data     (rd_data),
   .clk_out     (clk_out),
   .act_src_flat(act_src_flat)
);

// File: tb/sim_clksel_bank.sv
`timescale 1ns/1ps
module sim_clksel_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [5:0]  resume = '0;
   logic [6:0]  src = '0;
   logic [31:0] rd0, rd1;
   logic [5:0]  o0, o1;
   logic [31:0] shadow = '0;
   int          n_chk = 0;
   int          n_bad = 0;
   int          min_hi = 1000;

   always #10 clk = ~clk;   // 50 MHz

   clksel_bank #(.ALT_TABLE(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .resume(resume), .rd_data(rd0), .src_clk(src), .clk_out(o0));

   clksel_bank #(.ALT_TABLE(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .resume(resume), .rd_data(rd1), .src_clk(src), .clk_out(o1));

   // Source g toggles every g+3 cycles: half periods 3 (aux), 4..9 (generators 0..5)
   initial begin : srcgen
      int tk [7];
      for (int g = 0; g < 7; g++) tk[g] = 0;
      forever begin
         @(negedge clk);
         for (int g = 0; g < 7; g++) begin
            if (tk[g] == g + 2) begin
               tk[g] = 0;
               src[g] = ~src[g];
            end else tk[g]++;
         end
      end
   end

   // Shortest high pulse seen on any output (R8)
   initial begin : runt_mon
      int run [12];
      for (int k = 0; k < 12; k++) run[k] = 0;
      forever begin
         @(negedge clk);
         for (int k = 0; k < 12; k++) begin
            if ((k < 6) ? o0[k] : o1[k-6]) run[k]++;
            else begin
               if (run[k] > 0 && run[k] < min_hi) min_hi = run[k];
               run[k] = 0;
            end
         end
      end
   end

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   task automatic chk(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic bit ob(input int inst, input int sl);
      return inst != 0 ? o1[sl] : o0[sl];
   endfunction

   task automatic wr_shadow();
      @(negedge clk);
      wr_en = 1'b1; wr_data = shadow;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_slot(input int sl, input int s, input int d);
      shadow[sl*5 +: 5] = {3'(s), 2'(d)};
      wr_shadow();
   endtask

   // Waits for a rising output edge, then measures one high and one low phase
   task automatic measure(input int inst, input int sl, output int hi, output int lo);
      bit p, c, ok;
      int t;
      ok = 1'b0; hi = -1; lo = -1;
      p = ob(inst, sl);
      for (t = 0; t < 3000; t++) begin
         @(negedge clk);
         c = ob(inst, sl);
         if (!p && c) begin ok = 1'b1; break; end
         p = c;
      end
      if (ok) begin
         hi = 1;
         forever begin @(negedge clk); if (ob(inst, sl)) hi++; else break; end
         lo = 1;
         for (t = 0; t < 3000; t++) begin
            @(negedge clk);
            if (!ob(inst, sl)) lo++; else break;
         end
      end
   endtask

   task automatic expect_wave(input string tag, input int inst, input int sl,
                              input int ehi, input int elo);
      int hi, lo;
      measure(inst, sl, hi, lo);
      chk({tag, " high"}, hi, ehi);
      chk({tag, " low"}, lo, elo);
   endtask

   task automatic t_reset();
      chk("R11 control word after reset", rd0, 0);
      chk("R11 outputs after reset", {o1, o0}, 0);
      begin
         int seen = 0;
         repeat (60) begin @(negedge clk); if ((o0 | o1) != 0) seen++; end
         chk("R2 all slots off stay low", seen, 0);
      end
   endtask

   task automatic t_resume_default();
      @(negedge clk); resume = 6'b100000;
      @(negedge clk); resume = '0;
      chk("R7 default remembered source is 1", rd0[29:27], 1);
      chk("R7 divide code untouched by resume", rd0[26:25], 0);
      shadow = rd0;
   endtask

   task automatic t_readback();
      shadow = 32'hFFFF_FFFF; wr_shadow();
      chk("R1 read back all ones, bits 31..30 zero", rd0, 32'h3FFF_FFFF);
      shadow = 32'h1234_5678; wr_shadow();
      chk("R1 read back pattern", rd0, 32'h1234_5678 & 32'h3FFF_FFFF);
      shadow = '0; wr_shadow();
      chk("R1 read back zero", rd0, 0);
      repeat (80) @(negedge clk);
   endtask

   task automatic t_ratios();
      set_slot(0, 1, 0);   // aux, ratio 1
      set_slot(1, 2, 1);   // gen0, ratio 4
      set_slot(2, 7, 3);   // gen5, ratio 2
      set_slot(3, 4, 2);   // gen2, code 2
      repeat (150) @(negedge clk);
      expect_wave("R3 R6 aux code 1 passes through", 0, 0, 3, 3);
      expect_wave("R3 R4 gen0 code 1 divides by 4", 0, 1, 16, 16);
      expect_wave("R3 R4 R6 gen5 code 3 divides by 2", 0, 2, 18, 18);
      expect_wave("R4 std table code 2 is ratio 1", 0, 3, 6, 6);
      expect_wave("R5 R6 alt table code 2 is ratio 3", 1, 3, 12, 24);
      expect_wave("R5 alt table code 1 is ratio 4", 1, 1, 16, 16);
      expect_wave("R5 alt table code 0 is ratio 1", 1, 0, 3, 3);
   endtask

   task automatic t_disable_resume();
      int seen = 0;
      set_slot(4, 6, 0);   // gen4, half period 8
      repeat (60) @(negedge clk);
      expect_wave("R3 gen4 code 6", 0, 4, 8, 8);
      set_slot(4, 0, 0);
      chk("R2 source field reads 0", rd0[24:22], 0);
      repeat (20) @(negedge clk);
      repeat (100) begin @(negedge clk); if (o0[4]) seen++; end
      chk("R2 disabled slot output low", seen, 0);
      @(negedge clk); resume = 6'b010000;
      @(negedge clk); resume = '0;
      chk("R7 resume restores code 6", rd0[24:22], 6);
      shadow = rd0;
      repeat (40) @(negedge clk);
      expect_wave("R7 resumed waveform", 0, 4, 8, 8);
   endtask

   task automatic t_switch();
      set_slot(0, 3, 3);   // aux ratio 1 -> gen1 ratio 2
      repeat (60) @(negedge clk);
      expect_wave("R8 switched to gen1 ratio 2", 0, 0, 10, 10);
   endtask

   task automatic t_div_only();
      int hi, lo;
      set_slot(1, 2, 3);   // gen0: ratio 4 -> ratio 2
      measure(0, 1, hi, lo);
      chk("R9 first high after divide change", hi, 8);
      chk("R9 first low after divide change", lo, 8);
   endtask

   task automatic t_independent();
      int hi, lo;
      fork
         measure(0, 2, hi, lo);
         begin
            repeat (20) @(negedge clk);
            set_slot(3, 5, 3);
         end
      join
      chk("R10 slot 2 high during slot 3 write", hi, 18);
      chk("R10 slot 2 low during slot 3 write", lo, 18);
      chk("R10 slot 2 field unchanged", rd0[14:10], 5'b11111);
   endtask

   initial begin : main
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_resume_default();
      t_readback();
      t_ratios();
      t_disable_resume();
      t_switch();
      t_div_only();
      t_independent();
      n_chk++;
      if (min_hi < 3) begin
         n_bad++;
         $display("FAIL R8 runt pulse: actual %0d expected >= 3", min_hi);
      end
      summary();
      $finish;
   end
endmodule